// File: doc/BRIEF.md
# Optimistic Coherence Resolution Controller

This controller closes an optimistic execution window of a near-data accelerator. While the accelerator kernel runs it issues no coherence traffic; CPU writes are recorded in a CPU write signature, and this block gates those updates. When the kernel reports completion, the controller freezes the CPU write signature and asks the external signature tracker whether the accelerator read set collides with the CPU write set.

On a collision the controller runs a recovery sequence. The CPU cache flushes its dirty lines that hit the accelerator read set, then the accelerator cache drops all of its uncommitted lines, then the signatures are erased, and then the kernel is restarted. Without a collision it asks the CPU cache to invalidate clean lines that hit the accelerator write set, and then tells the accelerator cache to commit its buffered updates. Each step is a request held high until its acknowledge arrives. A retry counter bounds the number of restarts. When the bound is reached an error flag is raised and the controller goes back to idle.

States and transitions: IDLE goes to RUN on `start_i`. RUN goes to RESOLVE on `core_done_i`. RESOLVE goes to FLUSH on an acknowledged conflict, or to INVAL_CPU on an acknowledged no-conflict. FLUSH goes to INVAL_NDA. INVAL_NDA goes to CLEAR. CLEAR goes to RESTART, or to IDLE with the error flag set once the retry limit is reached. RESTART goes to RUN. INVAL_CPU goes to COMMIT. COMMIT goes to DONE. DONE goes to IDLE unconditionally.

Top module: `optres_ctrl`

## Requirements
- R1: During and right after reset the controller is idle: every request output, `core_run_o`, `sig_upd_o`, `done_o` and `err_o` are 0.
- R2: `start_i` seen in IDLE raises `core_run_o` on the next cycle. While `core_run_o` is high, `sig_upd_o` follows `cpu_wr_i`.
- R3: `core_done_i` in RUN leads to `res_req_o` on the next cycle. From then until the window reopens, `sig_upd_o` stays 0 whatever `cpu_wr_i` does.
- R4: An acknowledged conflict (`res_ack_i` with `res_conflict_i`=1) drives, one request at a time, `cpu_flush_req_o`, then `nda_inval_req_o`, then `sig_clr_req_o`, then `core_rst_req_o`.
- R5: `nda_inval_req_o` rises only in the cycle after `cpu_flush_req_o` was acknowledged by `cpu_ack_i`.
- R6: `core_ack_i` on a restart request raises `core_run_o` again on the next cycle, which opens a new window.
- R7: An acknowledged no-conflict (`res_conflict_i`=0) drives `cpu_inval_req_o`, then `nda_commit_req_o`, then a one-cycle `done_o` pulse, and the controller returns to IDLE.
- R8: After MAX_RETRY restarts in one run, the next acknowledged signature clear raises `err_o` instead of a restart request, and the controller is idle. `err_o` stays high until the next accepted `start_i`.
- R9: At most one of the request outputs, `core_run_o` and `done_o` is high in any cycle. A request stays high until its acknowledge is seen.
- R10: `start_i` has no effect outside IDLE: the command sequence of the running window is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launch a kernel window |
| core_run_o | output | 1 | Kernel running (window open) |
| core_done_i | input | 1 | Kernel finished |
| core_rst_req_o | output | 1 | Request kernel restart |
| core_ack_i | input | 1 | Restart acknowledge |
| res_req_o | output | 1 | Request conflict result from the signature tracker |
| res_ack_i | input | 1 | Conflict result valid |
| res_conflict_i | input | 1 | 1 = read set hits CPU write set |
| cpu_wr_i | input | 1 | CPU write to be recorded in its signature |
| sig_upd_o | output | 1 | Enable for the CPU write signature update |
| sig_clr_req_o | output | 1 | Request erase of all signatures |
| sig_ack_i | input | 1 | Erase acknowledge |
| cpu_flush_req_o | output | 1 | CPU flush of dirty lines hitting the read set |
| cpu_inval_req_o | output | 1 | CPU invalidate of clean lines hitting the write set |
| cpu_ack_i | input | 1 | CPU cache acknowledge |
| nda_inval_req_o | output | 1 | Accelerator drop of uncommitted lines |
| nda_commit_req_o | output | 1 | Accelerator commit of buffered updates |
| nda_ack_i | input | 1 | Accelerator cache acknowledge |
| done_o | output | 1 | One-cycle pulse on successful commit |
| err_o | output | 1 | Retry limit reached |

## Verification
Every cycle, the assertions check that requests are mutually exclusive and held until acknowledged. They also check that the accelerator invalidation follows an acknowledged flush, that the signature update is frozen during resolution, that the retry count stays within bounds, that the error flag rises only when the controller is idle, and that the done pulse lasts one cycle. Some behaviour only the bench's scenarios can show: the full order of commands in the commit path and in the recovery path, the exact number of restarts before the error, that `start_i` is ignored in mid-run, and that the error flag is cleared by a new launch. The bench uses varied conflict patterns and acknowledge latencies for these.

// File: rtl/optres_pkg.sv
package optres_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RUN,
        ST_RESOLVE,
        ST_FLUSH,
        ST_INVAL_NDA,
        ST_CLEAR,
        ST_RESTART,
        ST_INVAL_CPU,
        ST_COMMIT,
        ST_DONE
    } optres_state_e;

    localparam int unsigned NUM_REQ = 7;

endpackage

// File: rtl/optres_retry.sv
module optres_retry #(
    parameter int unsigned MAX_RETRY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic at_limit_o
);
    localparam int unsigned CW = (MAX_RETRY < 1) ? 1 : $clog2(MAX_RETRY + 1);
    localparam logic [CW-1:0] LIMIT = CW'(MAX_RETRY);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q <= '0;
        end else if (inc_i && cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign at_limit_o = (cnt_q == LIMIT);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIMIT); // R8

    AST_NO_INC_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        inc_i |-> !at_limit_o); // R8

endmodule

// File: rtl/optres_sig_gate.sv
module optres_sig_gate (
    input  logic cpu_wr_i,
    input  logic window_i,
    output logic sig_upd_o
);
    always_comb begin
        sig_upd_o = cpu_wr_i & window_i;
    end
endmodule

// File: rtl/optres_fsm.sv
module optres_fsm
    import optres_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic core_done_i,
    input  logic core_ack_i,
    input  logic res_ack_i,
    input  logic res_conflict_i,
    input  logic sig_ack_i,
    input  logic cpu_ack_i,
    input  logic nda_ack_i,
    input  logic at_limit_i,
    output logic retry_clr_o,
    output logic retry_inc_o,
    output logic window_o,
    output logic core_run_o,
    output logic core_rst_req_o,
    output logic res_req_o,
    output logic sig_clr_req_o,
    output logic cpu_flush_req_o,
    output logic cpu_inval_req_o,
    output logic nda_inval_req_o,
    output logic nda_commit_req_o,
    output logic done_o,
    output logic err_o
);
    optres_state_e state_q, state_d;
    logic          err_q, err_d;

    // next state
    always_comb begin
        state_d = state_q;
        err_d   = err_q;
        unique case (state_q)
            ST_IDLE: if (start_i) begin
                state_d = ST_RUN;
                err_d   = 1'b0;
            end
            ST_RUN:       if (core_done_i) state_d = ST_RESOLVE;
            ST_RESOLVE:   if (res_ack_i)   state_d = res_conflict_i ? ST_FLUSH : ST_INVAL_CPU;
            ST_FLUSH:     if (cpu_ack_i)   state_d = ST_INVAL_NDA;
            ST_INVAL_NDA: if (nda_ack_i)   state_d = ST_CLEAR;
            ST_CLEAR: if (sig_ack_i) begin
                if (at_limit_i) begin
                    state_d = ST_IDLE;
                    err_d   = 1'b1;
                end else begin
                    state_d = ST_RESTART;
                end
            end
            ST_RESTART:   if (core_ack_i)  state_d = ST_RUN;
            ST_INVAL_CPU: if (cpu_ack_i)   state_d = ST_COMMIT;
            ST_COMMIT:    if (nda_ack_i)   state_d = ST_DONE;
            ST_DONE:      state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= err_d;
        end
    end

    // outputs
    always_comb begin
        core_run_o       = (state_q == ST_RUN);
        window_o         = (state_q == ST_RUN);
        res_req_o        = (state_q == ST_RESOLVE);
        cpu_flush_req_o  = (state_q == ST_FLUSH);
        nda_inval_req_o  = (state_q == ST_INVAL_NDA);
        sig_clr_req_o    = (state_q == ST_CLEAR);
        core_rst_req_o   = (state_q == ST_RESTART);
        cpu_inval_req_o  = (state_q == ST_INVAL_CPU);
        nda_commit_req_o = (state_q == ST_COMMIT);
        done_o           = (state_q == ST_DONE);
        err_o            = err_q;
        retry_clr_o      = (state_q == ST_IDLE) && start_i;
        retry_inc_o      = (state_q == ST_CLEAR) && sig_ack_i && !at_limit_i;
    end

    logic [NUM_REQ-1:0] req_vec;
    logic               req_acked;
    assign req_vec = {core_rst_req_o, res_req_o, sig_clr_req_o, cpu_flush_req_o,
                      cpu_inval_req_o, nda_inval_req_o, nda_commit_req_o};
    assign req_acked = (core_rst_req_o & core_ack_i) | (res_req_o & res_ack_i)
                     | (sig_clr_req_o & sig_ack_i)
                     | ((cpu_flush_req_o | cpu_inval_req_o) & cpu_ack_i)
                     | ((nda_inval_req_o | nda_commit_req_o) & nda_ack_i);

    AST_ONE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_vec, core_run_o, done_o})); // R9

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_vec) && !req_acked |=> $stable(req_vec)); // R9

    AST_FLUSH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nda_inval_req_o) |-> $past(cpu_flush_req_o && cpu_ack_i)); // R5

    AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> !(|req_vec) && !core_run_o); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7

endmodule

// File: rtl/optres_ctrl.sv
module optres_ctrl #(
    parameter int unsigned MAX_RETRY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic core_run_o,
    input  logic core_done_i,
    output logic core_rst_req_o,
    input  logic core_ack_i,
    output logic res_req_o,
    input  logic res_ack_i,
    input  logic res_conflict_i,
    input  logic cpu_wr_i,
    output logic sig_upd_o,
    output logic sig_clr_req_o,
    input  logic sig_ack_i,
    output logic cpu_flush_req_o,
    output logic cpu_inval_req_o,
    input  logic cpu_ack_i,
    output logic nda_inval_req_o,
    output logic nda_commit_req_o,
    input  logic nda_ack_i,
    output logic done_o,
    output logic err_o
);
    logic retry_clr, retry_inc, at_limit, window;

    optres_fsm u_fsm (
        .clk              (clk),
        .rst_n            (rst_n),
        .start_i          (start_i),
        .core_done_i      (core_done_i),
        .core_ack_i       (core_ack_i),
        .res_ack_i        (res_ack_i),
        .res_conflict_i   (res_conflict_i),
        .sig_ack_i        (sig_ack_i),
        .cpu_ack_i        (cpu_ack_i),
        .nda_ack_i        (nda_ack_i),
        .at_limit_i       (at_limit),
        .retry_clr_o      (retry_clr),
        .retry_inc_o      (retry_inc),
        .window_o         (window),
        .core_run_o       (core_run_o),
        .core_rst_req_o   (core_rst_req_o),
        .res_req_o        (res_req_o),
        .sig_clr_req_o    (sig_clr_req_o),
        .cpu_flush_req_o  (cpu_flush_req_o),
        .cpu_inval_req_o  (cpu_inval_req_o),
        .nda_inval_req_o  (nda_inval_req_o),
        .nda_commit_req_o (nda_commit_req_o),
        .done_o           (done_o),
        .err_o            (err_o)
    );

    optres_retry #(.MAX_RETRY(MAX_RETRY)) u_retry (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (retry_clr),
        .inc_i      (retry_inc),
        .at_limit_o (at_limit)
    );

    optres_sig_gate u_gate (
        .cpu_wr_i  (cpu_wr_i),
        .window_i  (window),
        .sig_upd_o (sig_upd_o)
    );

    AST_SIG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !core_run_o |-> !sig_upd_o); // R3

endmodule

// File: tb/tb_optres_ctrl.sv
module tb_optres_ctrl;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, core_done_i = 1'b0, core_ack_i = 1'b0;
    logic res_ack_i = 1'b0, res_conflict_i = 1'b0, cpu_wr_i = 1'b0;
    logic sig_ack_i = 1'b0, cpu_ack_i = 1'b0, nda_ack_i = 1'b0;
    logic core_run_o, core_rst_req_o, res_req_o, sig_upd_o, sig_clr_req_o;
    logic cpu_flush_req_o, cpu_inval_req_o, nda_inval_req_o, nda_commit_req_o;
    logic done_o, err_o;

    always #10 clk = ~clk;

    optres_ctrl #(.MAX_RETRY(2)) dut (.*);

    int total = 0;
    int bad   = 0;
    int exp_q[$];
    int conflicts_left = 0;
    int lat = 2;
    int run_lat = 3;
    bit mon_en = 1'b0;

    localparam int C_RUN = 0, C_RES = 1, C_FLUSH = 2, C_INVN = 3, C_CLR = 4,
                   C_RST = 5, C_INVC = 6, C_COMMIT = 7, C_DONE = 8, C_ERR = 9;

    function automatic string tag_of(int c);
        case (c)
            C_RUN:    return "R2/R6 run";
            C_RES:    return "R3 resolve";
            C_FLUSH:  return "R4 flush";
            C_INVN:   return "R5 nda-inval";
            C_CLR:    return "R4 clear";
            C_RST:    return "R6 restart";
            C_INVC:   return "R7 cpu-inval";
            C_COMMIT: return "R7 commit";
            C_DONE:   return "R7 done";
            default:  return "R8 error";
        endcase
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // driver-side helpers
    task automatic push(int c);
        exp_q.push_back(c);
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic push_conflict_round();
        push(C_RES); push(C_FLUSH); push(C_INVN); push(C_CLR);
    endtask

    task automatic push_commit_tail();
        push(C_RES); push(C_INVC); push(C_COMMIT); push(C_DONE);
    endtask

    // responder: models kernel, tracker and caches
    initial begin
        int cnt = 0;
        bit pulsing = 1'b0;
        forever begin
            @(negedge clk);
            if (pulsing) begin
                core_done_i = 0; res_ack_i = 0; cpu_ack_i = 0;
                nda_ack_i = 0; sig_ack_i = 0; core_ack_i = 0;
                pulsing = 0; cnt = 0;
            end else if (!rst_n) begin
                cnt = 0;
            end else if (core_run_o) begin
                cnt++;
                if (cnt >= run_lat) begin core_done_i = 1; pulsing = 1; end
            end else if (res_req_o || cpu_flush_req_o || cpu_inval_req_o ||
                         nda_inval_req_o || nda_commit_req_o ||
                         sig_clr_req_o || core_rst_req_o) begin
                cnt++;
                if (cnt >= lat) begin
                    pulsing = 1;
                    if (res_req_o) begin
                        res_conflict_i = (conflicts_left > 0);
                        if (conflicts_left > 0) conflicts_left--;
                        res_ack_i = 1;
                    end else if (cpu_flush_req_o || cpu_inval_req_o) cpu_ack_i = 1;
                    else if (nda_inval_req_o || nda_commit_req_o) nda_ack_i = 1;
                    else if (sig_clr_req_o) sig_ack_i = 1;
                    else core_ack_i = 1;
                end
            end else begin
                cnt = 0;
            end
        end
    end

    // monitor: pops expected commands as outputs rise
    initial begin
        logic [9:0] prev = '0;
        forever begin
            logic [9:0] cur;
            @(negedge clk);
            #1;
            cur = {err_o, done_o, nda_commit_req_o, cpu_inval_req_o, core_rst_req_o,
                   sig_clr_req_o, nda_inval_req_o, cpu_flush_req_o, res_req_o, core_run_o};
            if (mon_en) begin
                for (int i = 0; i < 10; i++) begin
                    if (cur[i] && !prev[i]) begin
                        if (exp_q.size() == 0) begin
                            check(1'b0, tag_of(i), i, -1);
                        end else begin
                            int e;
                            e = exp_q.pop_front();
                            check(e == i, tag_of(e), i, e);
                        end
                    end
                end
                if ($countones(cur[8:0]) > 1)
                    check(1'b0, "R9 exclusive", $countones(cur[8:0]), 1);
            end
            prev = cur;
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_up();
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        #2;
        check({core_run_o, res_req_o, cpu_flush_req_o, cpu_inval_req_o, nda_inval_req_o,
               nda_commit_req_o, sig_clr_req_o, core_rst_req_o, done_o, err_o, sig_upd_o} == '0,
              "R1 reset", 1, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #2;
        check(core_run_o == 0 && err_o == 0 && done_o == 0, "R1 after reset", core_run_o, 0);
        mon_en = 1'b1;

        // commit path, with R2/R3 signature gating
        run_lat = 8; lat = 4;
        push(C_RUN); push_commit_tail();
        pulse_start();
        #2;
        check(core_run_o == 1, "R2 run next cycle", core_run_o, 1);
        cpu_wr_i = 1; #1;
        check(sig_upd_o == 1, "R2 update open", sig_upd_o, 1);
        cpu_wr_i = 0; #1;
        check(sig_upd_o == 0, "R2 update follows", sig_upd_o, 0);
        while (!res_req_o) @(negedge clk);
        #2; cpu_wr_i = 1; #1;
        check(sig_upd_o == 0, "R3 frozen in resolve", sig_upd_o, 0);
        while (!cpu_inval_req_o) @(negedge clk);
        #2;
        check(sig_upd_o == 0, "R3 frozen in cpu-inval", sig_upd_o, 0);
        cpu_wr_i = 0;
        drain();
        check(core_run_o == 0 && done_o == 0, "R7 idle after done", core_run_o, 0);

        // one conflict then commit, quick acknowledges
        run_lat = 2; lat = 1; conflicts_left = 1;
        push(C_RUN); push_conflict_round(); push(C_RST);
        push(C_RUN); push_commit_tail();
        pulse_start();
        drain();
        check(err_o == 0, "R6 recovered without error", err_o, 0);

        // retry limit: three conflicts with MAX_RETRY=2
        run_lat = 3; lat = 3; conflicts_left = 3;
        push(C_RUN);
        push_conflict_round(); push(C_RST); push(C_RUN);
        push_conflict_round(); push(C_RST); push(C_RUN);
        push_conflict_round(); push(C_ERR);
        pulse_start();
        drain();
        check(err_o == 1, "R8 error raised", err_o, 1);
        check(core_run_o == 0 && core_rst_req_o == 0, "R8 idle on error", core_run_o, 0);
        repeat (5) @(negedge clk);
        #2;
        check(err_o == 1, "R8 error held", err_o, 1);

        // relaunch clears error; start pulses in mid-run are ignored (R10)
        run_lat = 4; lat = 2; conflicts_left = 1;
        push(C_RUN); push_conflict_round(); push(C_RST);
        push(C_RUN); push_commit_tail();
        pulse_start();
        #2;
        check(err_o == 0, "R8 error cleared by start", err_o, 0);
        pulse_start();
        while (!cpu_flush_req_o) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        drain();
        check(exp_q.size() == 0 && core_run_o == 0, "R10 start ignored", core_run_o, 0);

        finish_up();
    end

endmodule